// File: doc/BRIEF.md
# Coprocessor Reset and Halt Controller

This block is the host-side control register for a secondary processor. The host writes a control word. Bit 0 of that word is the run/reset control and bit 1 is the halt request. From these two bits the block drives a one-cycle reset pulse and a halt level into the coprocessor. It also keeps a small status byte that the host can read at any time.

The status that reads back is not simply the value that was written:
- Holding the coprocessor in reset makes the halt-request bit read as 1.
- When the coprocessor reports that it has stopped, the halt-request bit reads as 0.

A grant output follows the read-back halt-request bit. That grant gates access by the host, and by a second host-side master, to the coprocessor's program RAM. The address decoding and the RAM itself are not part of this block.

Top module: `copro_rst_halt_ctrl`

## Requirements
- R1: After synchronous reset, `status_o` is 0x02, `halt_o` is 1, `ram_grant_o` is 1 and `rst_pulse_o` is 0.
- R2: A write with data bit 0 = 1, when stored status bit 0 is 0, raises `rst_pulse_o` for exactly one cycle. That cycle is the cycle following the write cycle.
- R3: A write with data bit 0 = 1, when stored status bit 0 is already 1, produces no reset pulse.
- R4: A write with data bit 0 = 1 sets `halt_o` to data bit 1 in the following cycle: 1 means halted, 0 means running.
- R5: A write with data bit 0 = 1 stores data bits 1:0 into status bits 1:0. This holds unless R7 applies.
- R6: A write with data bit 0 = 0 sets `halt_o` to 1 and status to 0x02, whatever data bit 1 holds. This holds unless R7 applies.
- R7: When `stopped_i` is 1 during a write, stored status bit 1 becomes 0 after the R5/R6 update. `halt_o` is not affected.
- R8: `ram_grant_o` equals stored status bit 1. It changes in the cycle after the write that changes that bit, and not before.
- R9: Status bits 7:2 always read 0. Write data bits above bit 1, such as the high byte of a word write, have no effect on any output.
- R10: Without a write, status, `halt_o` and `ram_grant_o` hold their values and no pulse is produced, even when `stopped_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | DATA_W | Host write data; only bits 1:0 are used |
| stopped_i | input | 1 | Coprocessor reports it is stopped |
| rst_pulse_o | output | 1 | One-cycle reset pulse to the coprocessor |
| halt_o | output | 1 | Halt level to the coprocessor |
| status_o | output | STAT_W | Readable status byte |
| ram_grant_o | output | 1 | Enable for host access to program RAM |

## Verification
The bench builds the block with DATA_W = 16 and STAT_W = 8. The 16-bit data path lets a word write carry a fully set high byte, so the test can confirm that those bits and bits 7:2 of the low byte change nothing. The 8-bit status exposes six pad bits that must read zero. Grant timing is sampled in the write cycle itself and again one cycle later, which pins down the single register stage.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int CTRL_W = 2;

  // Stored control bits: index 1 = halt request, index 0 = run (reset released)
  typedef struct packed {
    logic busreq;
    logic run;
  } ctl_t;

  localparam ctl_t CTL_HOLD = '{busreq: 1'b1, run: 1'b0};
endpackage

// File: rtl/copro_next.sv
module copro_next
  import copro_pkg::*;
(
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_ctl,
  input  logic              stopped,
  input  ctl_t              cur,
  input  logic              cur_halt,
  output ctl_t              nxt,
  output logic              nxt_halt,
  output logic              fire
);
  always_comb begin
    nxt      = cur;
    nxt_halt = cur_halt;
    fire     = 1'b0;
    if (wr_en) begin
      if (wr_ctl[0]) begin
        fire       = ~cur.run;
        nxt_halt   = wr_ctl[1];
        nxt.run    = 1'b1;
        nxt.busreq = wr_ctl[1];
      end else begin
        nxt_halt = 1'b1;
        nxt      = CTL_HOLD;
      end
      if (stopped) nxt.busreq = 1'b0;
    end
  end
endmodule

// File: rtl/copro_pulse.sv
module copro_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= fire;
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/copro_rst_halt_ctrl.sv
module copro_rst_halt_ctrl
  import copro_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stopped_i,
  output logic              rst_pulse_o,
  output logic              halt_o,
  output logic [STAT_W-1:0] status_o,
  output logic              ram_grant_o
);
  localparam int PAD_W = STAT_W - CTRL_W;

  ctl_t ctl_q, ctl_d;
  logic halt_d, fire;
  logic unused_hi_bits;

  assign unused_hi_bits = ^wr_data[DATA_W-1:CTRL_W];

  copro_next u_next (
    .wr_en    (wr_en),
    .wr_ctl   (wr_data[CTRL_W-1:0]),
    .stopped  (stopped_i),
    .cur      (ctl_q),
    .cur_halt (halt_o),
    .nxt      (ctl_d),
    .nxt_halt (halt_d),
    .fire     (fire)
  );

  copro_pulse u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .pulse_o (rst_pulse_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= CTL_HOLD;
      halt_o      <= 1'b1;
      ram_grant_o <= 1'b1;
    end else begin
      ctl_q       <= ctl_d;
      halt_o      <= halt_d;
      ram_grant_o <= ctl_d.busreq;
    end
  end

  assign status_o = {{PAD_W{1'b0}}, ctl_q};

  // R2
  pulse_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse_o |-> ($past(wr_en) && !$past(status_o[0]) && status_o[0]));

  // R6
  hold_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[0]) |=> halt_o);

  // R7
  stopped_busreq_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && stopped_i) |=> !status_o[1]);

  // R8
  grant_track_chk: assert property (@(posedge clk) disable iff (rst)
    ram_grant_o == status_o[1]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(status_o) && $stable(halt_o) && !rst_pulse_o));
endmodule

// File: tb/copro_rst_halt_ctrl_bench.sv
`timescale 1ns/1ps
module copro_rst_halt_ctrl_bench;
  localparam int DATA_W = 16;
  localparam int STAT_W = 8;

  logic clk = 1'b0;
  logic rst, wr_en, stopped_i;
  logic [DATA_W-1:0] wr_data;
  logic rst_pulse_o, halt_o, ram_grant_o;
  logic [STAT_W-1:0] status_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  copro_rst_halt_ctrl #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_copro_rst_halt_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .stopped_i(stopped_i),
    .rst_pulse_o(rst_pulse_o), .halt_o(halt_o), .status_o(status_o),
    .ram_grant_o(ram_grant_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one write; returns at the negedge after the capturing edge
  task automatic wr(input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic expect_all(input string req, input int st, input int h, input int p);
    chk({req, " status"}, int'(status_o), st);
    chk({req, " halt"}, int'(halt_o), h);
    chk({req, " pulse"}, int'(rst_pulse_o), p);
    chk({req, " grant"}, int'(ram_grant_o), (st >> 1) & 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_all("R1", 8'h02, 1, 0);
  endtask

  task automatic t_release();
    wr(16'h0001);
    expect_all("R2 R4 R5", 8'h01, 0, 1);
    @(negedge clk);
    chk("R2 pulse width", int'(rst_pulse_o), 0);
  endtask

  task automatic t_rewrite();
    wr(16'h0001);
    expect_all("R3", 8'h01, 0, 0);
    // grant must still be old in the write cycle itself
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0003;
    chk("R8 grant before edge", int'(ram_grant_o), 0);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    expect_all("R3 R4 R5 R8", 8'h03, 1, 0);
  endtask

  task automatic t_hold();
    wr(16'h0002);
    expect_all("R6 bit1=1", 8'h02, 1, 0);
    wr(16'h0000);
    expect_all("R6 bit1=0", 8'h02, 1, 0);
    wr(16'h0003);
    expect_all("R2 after hold", 8'h03, 1, 1);
  endtask

  task automatic t_stopped();
    stopped_i = 1'b1;
    wr(16'h0003);
    expect_all("R7 run", 8'h01, 1, 0);
    wr(16'h0000);
    expect_all("R7 hold", 8'h00, 1, 0);
    stopped_i = 1'b0;
    repeat (2) @(negedge clk);
    expect_all("R10 idle", 8'h00, 1, 0);
  endtask

  task automatic t_upper();
    wr(16'hFFFD);
    expect_all("R9 word high bits", 8'h01, 0, 1);
    wr(16'hFF00);
    expect_all("R9 hold high bits", 8'h02, 1, 0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; stopped_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_release();
    t_rewrite();
    t_hold();
    t_stopped();
    t_upper();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule